// File: doc/BRIEF.md
# Receive Offset Calibration Unit

This block sits after the decimation filters of a two-channel (in-phase and quadrature) receive path. It removes the DC offset from every 15-bit two's complement sample. Each channel has a 10-bit two's complement offset register. One offset step is worth eight sample steps, so the register covers sample bits 12 down to 3. Every sample that is accepted has its channel's offset subtracted, and the result appears one cycle later. The result saturates at the 15-bit limits.

The offset registers can be filled in two ways. In automatic mode, a start pulse opens a measurement window. During it the unit sums the next 16 accepted samples of each channel, takes their average, rounds that average to the offset grid and loads the result. While the window is open it asks the analog front end to short its inputs. A separate external-calibration choice keeps the inputs connected, so that offsets from outside the block are measured as well. In user mode the host writes either register directly and no measurement runs. A sleep input stops the sample stream while the registers keep their contents.

Top module: `rx_offset_cal`

## Requirements
- R1: A sample is accepted when `smp_valid` is 1 and `rx_sleep` is 0. One cycle after acceptance, `out_valid` is 1 and each output is the channel sample minus 8 times its signed 10-bit offset register. `out_valid` is 0 one cycle after any cycle with no accepted sample.
- R2: The corrected output saturates at +16383 and -16384 and never wraps.
- R3: In automatic mode (`auto_mode`=1), a `cal_start` pulse while idle and awake makes `cal_busy` 1 from the next cycle. The pulse counts only as a start: the sample accepted in the start cycle is not measured. `cal_busy` falls at the clock edge that accepts the 16th accepted sample after the start.
- R4: At that edge each offset register is loaded with the following value. Take the sum of the 16 measured samples, divide by 16 and round toward minus infinity (this is the average A). Then take floor((A+4)/8) and limit it to the range -512..511.
- R5: `short_inputs` is 1 exactly while `cal_busy` is 1, unless `ext_cal` was 1 in the start cycle; in that case it stays 0.
- R6: In user mode (`auto_mode`=0), `usr_wr` loads `usr_data` into the register selected by `usr_ch` (0 = in-phase, 1 = quadrature), visible on `ofs_i`/`ofs_q` the next cycle. In automatic mode `usr_wr` has no effect. In user mode `cal_start` has no effect.
- R7: While `rx_sleep` is 1, no sample is accepted and `out_valid` is 0 the next cycle. An open measurement pauses and resumes after the sleep. The offset registers keep their values.
- R8: After a synchronous reset, both offset registers, both outputs, `out_valid`, `cal_busy` and `short_inputs` are 0.
- R9: A `cal_start` that arrives while `cal_busy` is 1 has no effect: the window still closes after 16 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sleep | input | 1 | Receive path asleep; samples ignored |
| auto_mode | input | 1 | 1 = automatic calibration, 0 = user-written offsets |
| ext_cal | input | 1 | Keep inputs connected during measurement |
| cal_start | input | 1 | Pulse to open a measurement window |
| usr_wr | input | 1 | Host write strobe for an offset register |
| usr_ch | input | 1 | Channel selected by a host write |
| usr_data | input | 10 | Offset value for a host write |
| smp_valid | input | 1 | Filter sample strobe |
| smp_i | input | 15 | In-phase filter sample |
| smp_q | input | 15 | Quadrature filter sample |
| cal_busy | output | 1 | Measurement window open |
| short_inputs | output | 1 | Request to short the analog inputs |
| ofs_i | output | 10 | In-phase offset register |
| ofs_q | output | 10 | Quadrature offset register |
| out_valid | output | 1 | Corrected sample strobe |
| out_i | output | 15 | Corrected in-phase sample |
| out_q | output | 15 | Corrected quadrature sample |

## Verification
Constant measurement inputs check the averaging and grid rounding. These are small positive and negative values that land on either side of a rounding boundary. Full-scale inputs check that the loaded offset saturates rather than wraps. Hand-written offsets at both register extremes, combined with extreme samples, separate saturating from wrapping subtraction. A measurement interrupted by sleep cycles shows that paused samples are neither counted nor corrected. A long stream of random samples, strobes, starts and host writes is compared every cycle against an independent model. This catches ordering slips between the load, the correction and the host writes.

// File: rtl/rx_ofs_pkg.sv
package rx_ofs_pkg;

    localparam int NCH = 2;

    typedef enum logic {
        CAL_IDLE = 1'b0,
        CAL_MEAS = 1'b1
    } cal_state_e;

    typedef struct packed {
        logic clr;
        logic take;
        logic last;
    } meas_ctl_t;

    // Limit a signed value to the range of a w-bit two's complement word
    function automatic logic signed [31:0] sat_to(input logic signed [31:0] v, input int w);
        logic signed [31:0] hi;
        logic signed [31:0] lo;
        hi = (32'sd1 <<< (w - 1)) - 32'sd1;
        lo = -(32'sd1 <<< (w - 1));
        if (v > hi)
            return hi;
        else if (v < lo)
            return lo;
        else
            return v;
    endfunction

endpackage

// File: rtl/rx_cal_ctrl.sv
module rx_cal_ctrl
    import rx_ofs_pkg::*;
#(
    parameter int AVG_LOG2 = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      awake,
    input  logic      smp_ok,
    input  logic      cal_start,
    input  logic      auto_mode,
    input  logic      ext_cal,
    output meas_ctl_t ctl,
    output logic      busy,
    output logic      short_req
);
    localparam int CNT_W = (AVG_LOG2 > 0) ? AVG_LOG2 : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    cal_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             ext_q;
    logic             start_ok;

    assign start_ok = cal_start & auto_mode & awake & (state == CAL_IDLE);
    assign ctl.clr  = start_ok;
    assign ctl.take = (state == CAL_MEAS) & smp_ok;
    assign ctl.last = ctl.take & (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CAL_IDLE;
            cnt   <= '0;
            ext_q <= 1'b0;
        end else if (start_ok) begin
            state <= CAL_MEAS;
            cnt   <= '0;
            ext_q <= ext_cal;
        end else if (ctl.last) begin
            state <= CAL_IDLE;
        end else if (ctl.take) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign busy      = (state == CAL_MEAS);
    assign short_req = busy & ~ext_q;

    // R3: the window closes only at the edge that takes its final sample
    a_r3_close_on_last: assert property (@(posedge clk) disable iff (rst)
        (busy && !ctl.last) |=> busy);

    // R9: an open window is never restarted
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !ctl.take) |=> $stable(cnt));

endmodule

// File: rtl/rx_ofs_store.sv
module rx_ofs_store
    import rx_ofs_pkg::*;
#(
    parameter int SMP_W     = 15,
    parameter int OFS_W     = 10,
    parameter int OFS_SHIFT = 3,
    parameter int AVG_LOG2  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  meas_ctl_t        ctl,
    input  logic [SMP_W-1:0] smp,
    input  logic             usr_we,
    input  logic [OFS_W-1:0] usr_data,
    output logic [OFS_W-1:0] ofs
);
    localparam int ACC_W = SMP_W + AVG_LOG2;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] acc_nxt;
    logic signed [31:0]      avg32;
    logic signed [31:0]      est32;
    logic signed [31:0]      lim32;
    logic        [OFS_W-1:0] ofs_ld;

    always_comb begin
        acc_nxt = acc + $signed({{AVG_LOG2{smp[SMP_W-1]}}, smp});
        avg32   = 32'(acc_nxt >>> AVG_LOG2);
        est32   = (avg32 + (32'sd1 <<< (OFS_SHIFT - 1))) >>> OFS_SHIFT;
        lim32   = sat_to(est32, OFS_W);
        ofs_ld  = lim32[OFS_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            ofs <= '0;
        end else begin
            if (ctl.clr)
                acc <= '0;
            else if (ctl.take)
                acc <= acc_nxt;
            if (ctl.last)
                ofs <= ofs_ld;
            else if (usr_we)
                ofs <= usr_data;
        end
    end

endmodule

// File: rtl/rx_ofs_corr.sv
module rx_ofs_corr
    import rx_ofs_pkg::*;
#(
    parameter int SMP_W     = 15,
    parameter int OFS_W     = 10,
    parameter int OFS_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_ok,
    input  logic [SMP_W-1:0] smp,
    input  logic [OFS_W-1:0] ofs,
    output logic [SMP_W-1:0] out
);
    logic signed [31:0] diff32;
    logic signed [31:0] lim32;

    always_comb begin
        diff32 = 32'($signed(smp)) - (32'($signed(ofs)) <<< OFS_SHIFT);
        lim32  = sat_to(diff32, SMP_W);
    end

    always_ff @(posedge clk) begin
        if (rst)
            out <= '0;
        else if (smp_ok)
            out <= lim32[SMP_W-1:0];
    end

    // R2: a non-negative offset never raises a sample (no wrap at the low end)
    a_r2_no_rise: assert property (@(posedge clk) disable iff (rst)
        (smp_ok && !ofs[OFS_W-1]) |=> ($signed(out) <= $signed($past(smp))));

    // R2: a negative offset never lowers a sample (no wrap at the high end)
    a_r2_no_fall: assert property (@(posedge clk) disable iff (rst)
        (smp_ok && ofs[OFS_W-1]) |=> ($signed(out) >= $signed($past(smp))));

endmodule

// File: rtl/rx_offset_cal.sv
module rx_offset_cal
    import rx_ofs_pkg::*;
#(
    parameter int SMP_W     = 15,
    parameter int OFS_W     = 10,
    parameter int OFS_SHIFT = 3,
    parameter int AVG_LOG2  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_sleep,
    input  logic             auto_mode,
    input  logic             ext_cal,
    input  logic             cal_start,
    input  logic             usr_wr,
    input  logic             usr_ch,
    input  logic [OFS_W-1:0] usr_data,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_i,
    input  logic [SMP_W-1:0] smp_q,
    output logic             cal_busy,
    output logic             short_inputs,
    output logic [OFS_W-1:0] ofs_i,
    output logic [OFS_W-1:0] ofs_q,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_i,
    output logic [SMP_W-1:0] out_q
);
    logic                        awake;
    logic                        smp_ok;
    meas_ctl_t                   ctl;
    logic [NCH-1:0][SMP_W-1:0]   smp_a;
    logic [NCH-1:0][SMP_W-1:0]   out_a;
    logic [NCH-1:0][OFS_W-1:0]   ofs_a;
    logic [NCH-1:0]              we_a;

    assign awake    = ~rx_sleep;
    assign smp_ok   = smp_valid & awake;
    assign smp_a[0] = smp_i;
    assign smp_a[1] = smp_q;

    rx_cal_ctrl #(
        .AVG_LOG2 (AVG_LOG2)
    ) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .awake     (awake),
        .smp_ok    (smp_ok),
        .cal_start (cal_start),
        .auto_mode (auto_mode),
        .ext_cal   (ext_cal),
        .ctl       (ctl),
        .busy      (cal_busy),
        .short_req (short_inputs)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign we_a[ch] = usr_wr & ~auto_mode & (usr_ch == 1'(ch));

        rx_ofs_store #(
            .SMP_W     (SMP_W),
            .OFS_W     (OFS_W),
            .OFS_SHIFT (OFS_SHIFT),
            .AVG_LOG2  (AVG_LOG2)
        ) i_store (
            .clk      (clk),
            .rst      (rst),
            .ctl      (ctl),
            .smp      (smp_a[ch]),
            .usr_we   (we_a[ch]),
            .usr_data (usr_data),
            .ofs      (ofs_a[ch])
        );

        rx_ofs_corr #(
            .SMP_W     (SMP_W),
            .OFS_W     (OFS_W),
            .OFS_SHIFT (OFS_SHIFT)
        ) i_corr (
            .clk    (clk),
            .rst    (rst),
            .smp_ok (smp_ok),
            .smp    (smp_a[ch]),
            .ofs    (ofs_a[ch]),
            .out    (out_a[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= smp_ok;
    end

    assign ofs_i = ofs_a[0];
    assign ofs_q = ofs_a[1];
    assign out_i = out_a[0];
    assign out_q = out_a[1];

    // R6: outside a window, automatic mode leaves both registers untouched
    a_r6_user_ignored: assert property (@(posedge clk) disable iff (rst)
        (!cal_busy && auto_mode) |=> ($stable(ofs_i) && $stable(ofs_q)));

    // R7: sleep retains the offsets unless the host writes in user mode
    a_r7_sleep_hold: assert property (@(posedge clk) disable iff (rst)
        (rx_sleep && !(usr_wr && !auto_mode)) |=> ($stable(ofs_i) && $stable(ofs_q)));

    // R7: nothing is presented after a sleeping cycle
    a_r7_sleep_no_valid: assert property (@(posedge clk) disable iff (rst)
        rx_sleep |=> !out_valid);

    // R5: the short request never appears outside a window
    a_r5_short_in_window: assert property (@(posedge clk) disable iff (rst)
        $rose(short_inputs) |-> $rose(cal_busy));

endmodule

// File: tb/test_rx_offset_cal.sv
module test_rx_offset_cal;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_sleep = 1'b0;
    logic        auto_mode = 1'b0;
    logic        ext_cal = 1'b0;
    logic        cal_start = 1'b0;
    logic        usr_wr = 1'b0;
    logic        usr_ch = 1'b0;
    logic [9:0]  usr_data = '0;
    logic        smp_valid = 1'b0;
    logic [14:0] smp_i = '0;
    logic [14:0] smp_q = '0;
    logic        cal_busy, short_inputs, out_valid;
    logic [9:0]  ofs_i, ofs_q;
    logic [14:0] out_i, out_q;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    rx_offset_cal i_rx_offset_cal (
        .clk(clk), .rst(rst), .rx_sleep(rx_sleep), .auto_mode(auto_mode),
        .ext_cal(ext_cal), .cal_start(cal_start), .usr_wr(usr_wr), .usr_ch(usr_ch),
        .usr_data(usr_data), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .cal_busy(cal_busy), .short_inputs(short_inputs), .ofs_i(ofs_i), .ofs_q(ofs_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    // ---------------- reference model ----------------
    int  m_ofs [2];
    int  m_out [2];
    bit  m_valid, m_busy, m_ext;
    int  m_q0 [$];
    int  m_q1 [$];

    function automatic int clampw(int v, int lo, int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic int floordiv(int a, int d);
        if (a >= 0) return a / d;
        return -((-a + d - 1) / d);
    endfunction

    function automatic int s15(logic [14:0] v);
        return (v[14]) ? int'(v) - 32768 : int'(v);
    endfunction

    function automatic int s10(logic [9:0] v);
        return (v[9]) ? int'(v) - 1024 : int'(v);
    endfunction

    function automatic int estimate(int q[$]);
        int sum = 0;
        foreach (q[k]) sum += q[k];
        return clampw(floordiv(floordiv(sum, 16) + 4, 8), -512, 511);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ofs = '{0, 0};
            m_out = '{0, 0};
            m_valid = 0; m_busy = 0; m_ext = 0;
            m_q0.delete(); m_q1.delete();
        end else begin
            bit ok, start, loaded;
            int si, sq;
            ok = smp_valid && !rx_sleep;
            start = cal_start && auto_mode && !m_busy && !rx_sleep;
            si = s15(smp_i);
            sq = s15(smp_q);
            loaded = 0;
            m_valid = ok;
            if (ok) begin
                m_out[0] = clampw(si - m_ofs[0] * 8, -16384, 16383);
                m_out[1] = clampw(sq - m_ofs[1] * 8, -16384, 16383);
            end
            if (start) begin
                m_busy = 1; m_ext = ext_cal;
                m_q0.delete(); m_q1.delete();
            end else if (m_busy && ok) begin
                m_q0.push_back(si);
                m_q1.push_back(sq);
                if (m_q0.size() == 16) begin
                    m_ofs[0] = estimate(m_q0);
                    m_ofs[1] = estimate(m_q1);
                    m_busy = 0;
                    loaded = 1;
                end
            end
            if (!loaded && usr_wr && !auto_mode)
                m_ofs[usr_ch] = s10(usr_data);
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 cal_busy", int'(cal_busy), int'(m_busy));
            chk("R5 short_inputs", int'(short_inputs), int'(m_busy && !m_ext));
            chk("R4/R6 ofs_i", s10(ofs_i), m_ofs[0]);
            chk("R4/R6 ofs_q", s10(ofs_q), m_ofs[1]);
            chk("R1/R7 out_valid", int'(out_valid), int'(m_valid));
            chk("R1/R2 out_i", s15(out_i), m_out[0]);
            chk("R1/R2 out_q", s15(out_q), m_out[1]);
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            finish_up();
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic user_write(bit ch, logic [9:0] d);
        usr_wr = 1; usr_ch = ch; usr_data = d;
        step();
        usr_wr = 0;
    endtask

    task automatic set_smp(int a, int b);
        smp_i = a[14:0];
        smp_q = b[14:0];
    endtask

    task automatic run_cal(int a, int b, bit ext, output int dur);
        auto_mode = 1; ext_cal = ext; smp_valid = 1; set_smp(a, b);
        cal_start = 1;
        step();
        cal_start = 0;
        dur = 0;
        while (cal_busy && dur < 100) begin
            dur++;
            step();
        end
    endtask

    initial begin
        int dur;
        repeat (3) step();
        rst = 0;
        step();
        // R8: reset state
        chk("R8 ofs_i after reset", s10(ofs_i), 0);
        chk("R8 ofs_q after reset", s10(ofs_q), 0);
        chk("R8 out_valid after reset", int'(out_valid), 0);
        chk("R8 cal_busy after reset", int'(cal_busy), 0);

        // R6: user writes
        user_write(0, 10'd5);
        user_write(1, 10'h3FE);
        chk("R6 user write I", s10(ofs_i), 5);
        chk("R6 user write Q", s10(ofs_q), -2);

        // R1: correction with bit-3 weighting
        smp_valid = 1; set_smp(100, -50);
        step();
        chk("R1 corrected I", s15(out_i), 60);
        chk("R1 corrected Q", s15(out_q), -34);
        smp_valid = 0;
        step();
        chk("R1 no valid without strobe", int'(out_valid), 0);

        // R2: saturation at both limits
        user_write(0, 10'h200);
        user_write(1, 10'd511);
        smp_valid = 1; set_smp(16000, -16000);
        step();
        chk("R2 saturate high", s15(out_i), 16383);
        chk("R2 saturate low", s15(out_q), -16384);

        // R6: cal_start ignored in user mode
        cal_start = 1;
        step();
        cal_start = 0;
        step();
        chk("R6 start ignored in user mode", int'(cal_busy), 0);

        // R6: write ignored in automatic mode
        auto_mode = 1;
        user_write(0, 10'd77);
        chk("R6 write ignored in auto mode", s10(ofs_i), -512);

        // R3/R4/R5/R9: automatic calibration, inputs shorted
        auto_mode = 1; ext_cal = 0; smp_valid = 1; set_smp(20, -12);
        cal_start = 1;
        step();
        chk("R3 busy after start", int'(cal_busy), 1);
        chk("R5 short during internal cal", int'(short_inputs), 1);
        dur = 1;
        step();
        dur++;
        while (cal_busy && dur < 100) begin
            if (dur == 4) cal_start = 1;  // R9: restart attempt
            else cal_start = 0;
            step();
            dur++;
        end
        cal_start = 0;
        chk("R3/R9 window length", dur - 1, 16);
        chk("R4 estimate I", s10(ofs_i), 3);
        chk("R4 estimate Q", s10(ofs_q), -1);

        // R5/R7: external calibration with sleep gaps
        ext_cal = 1; set_smp(-4, 4);
        cal_start = 1;
        step();
        cal_start = 0; ext_cal = 0;
        chk("R5 no short in external cal", int'(short_inputs), 0);
        repeat (5) step();
        rx_sleep = 1;
        repeat (2) step();
        chk("R7 no output while asleep", int'(out_valid), 0);
        chk("R7 busy held while asleep", int'(cal_busy), 1);
        repeat (6) step();
        rx_sleep = 0;
        while (cal_busy) step();
        chk("R4 rounding of -4", s10(ofs_i), 0);
        chk("R4 rounding of +4", s10(ofs_q), 1);

        // R4: saturated estimates
        run_cal(16383, -16384, 0, dur);
        chk("R4 estimate saturates high", s10(ofs_i), 511);
        chk("R4 estimate saturates low", s10(ofs_q), -512);

        // R7: sleep retains offsets
        rx_sleep = 1;
        repeat (10) step();
        rx_sleep = 0;
        step();
        chk("R7 offset kept over sleep", s10(ofs_i), 511);

        // mixed random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            smp_valid = ($urandom_range(0, 3) != 0);
            set_smp(int'($urandom_range(0, 32767)) - 16384, int'($urandom_range(0, 32767)) - 16384);
            rx_sleep  = ($urandom_range(0, 15) == 0);
            if (n % 500 == 0) auto_mode = ~auto_mode;
            cal_start = ($urandom_range(0, 40) == 0);
            ext_cal   = $urandom_range(0, 1);
            usr_wr    = ($urandom_range(0, 7) == 0);
            usr_ch    = $urandom_range(0, 1);
            usr_data  = 10'($urandom_range(0, 1023));
            step();
        end
        smp_valid = 0; cal_start = 0; usr_wr = 0; rx_sleep = 0;
        step();
        finish_up();
    end

endmodule